// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory down-counter that software must service inside a permitted window. A small word-addressed register port gives access to three registers: a command word at word 0 (write only), a configuration word at word 1 (read/write) and a sticky event word at word 2 (read only). The counter decrements on each pulse of an external tick strobe. When it runs out, that is a fault. A service command that arrives while the count is still above a programmed window limit is also a fault.

Each fault can raise an interrupt pulse, a processor-only reset pulse or a system-wide reset pulse, depending on three configuration bits. Counting can be frozen while the core is in debug or the system is idle, and the whole timer can be switched off.

The counter width is a parameter (`CNT_W`, default 12). The configuration fields are packed from bit 0 upward, and their positions are derived from `CNT_W`. The register port is plain control access, with no back-pressure. Reads are combinational, and writes take effect at the clock edge that samples them.

Top module: `win_watchdog`

## Requirements
- R1: After reset the configuration word reads all ones over its `2*CNT_W+6` bits, except the interrupt-enable, processor-only and off bits, which read 0 (0x3FFF2FFF for `CNT_W`=12). After reset the event word reads 0 and all three fault outputs are low.
- R2: Configuration layout, from bit 0 upward:
  - reload: bits `CNT_W-1:0`
  - interrupt enable: bit `CNT_W`
  - reset enable: bit `CNT_W+1`
  - processor-only select: bit `CNT_W+2`
  - off: bit `CNT_W+3`
  - window limit: bits `2*CNT_W+3:CNT_W+4`
  - debug freeze: bit `2*CNT_W+4`
  - idle freeze: bit `2*CNT_W+5`

  A write to word 1 stores these bits, and upper bits are dropped. Writes to other words leave the word unchanged. Word 0 and word 3 read 0.
- R3: A service command is a write to word 0 with bits 31:24 equal to 0xA5 and bit 0 equal to 1. Any other key, or bit 0 equal to 0, has no effect on the count, the outputs or the event word. A service command inside the window reloads the count from the reload field.
- R4: While running, each tick decrements the count. A tick taken while the count is 0 or 1 is an underflow, and it reloads the count instead. After a reload with value R, the underflow falls on tick max(R,1).
- R5: A service command while the count is greater than the window limit is an error. The count is left unchanged.
- R6: Fault outputs are registered and follow an underflow or error at the edge that detects it, for exactly one cycle per event:
  - interrupt = interrupt enable
  - processor reset = reset enable AND processor-only select
  - system reset = reset enable AND NOT processor-only select
- R7: Event word bit 0 records underflow and bit 1 records error. Each bit stays set until a read of word 2, which returns the bits and clears them at that edge. An event in the same cycle as the read is kept.
- R8: With debug freeze set, ticks are ignored while `dbg_active` is high. With idle freeze set, ticks are ignored while `idle_active` is high. With the freeze bit clear, the matching input has no effect. Service commands still work while frozen.
- R9: With the off bit set, ticks and service commands are ignored and no fault occurs.
- R10: A service command and a tick in the same cycle: the command is handled and the tick is dropped.
- R11: A write to word 1 does not change the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count strobe, one decrement per high cycle |
| dbg_active | input | 1 | Core is in debug state |
| idle_active | input | 1 | System is idle |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index: 0 command, 1 configuration, 2 events |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| fault_irq | output | 1 | Interrupt pulse |
| cpu_rst | output | 1 | Processor-only reset pulse |
| sys_rst | output | 1 | System-wide reset pulse |

## Verification
Every stimulus (a tick, a service write or a configuration write) is consumed at one rising edge. Fault pulses and event bits are due in the cycle straight after that edge, and the pulses must be gone one cycle later. Read data is due in the cycle the read is presented, and the clear takes effect at the edge that ends the read.

The bench drives every input just after a falling edge and samples at the next falling edge, so each check lands exactly one register stage after its stimulus. The count itself is hidden, so the bench observes it through the tick on which the next underflow pulse falls. This is how it confirms reloads, held counts after errors, ignored commands and frozen ticks.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned KEY_W   = 8;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_MODE = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              stat_uf,
  input  logic              stat_err,
  output logic [DW-1:0]     bus_rdata,
  output logic              restart_req,
  output logic              stat_rd,
  output logic [CNT_W-1:0]  cfg_reload,
  output logic [CNT_W-1:0]  cfg_delta,
  output logic              cfg_irq_en,
  output logic              cfg_rst_en,
  output logic              cfg_proc,
  output logic              cfg_dis,
  output logic              cfg_hdbg,
  output logic              cfg_hidl
);
  localparam int unsigned P_IRQ  = CNT_W;
  localparam int unsigned P_RST  = CNT_W + 1;
  localparam int unsigned P_PROC = CNT_W + 2;
  localparam int unsigned P_DIS  = CNT_W + 3;
  localparam int unsigned P_DLO  = CNT_W + 4;
  localparam int unsigned P_HDBG = 2 * CNT_W + 4;
  localparam int unsigned P_HIDL = 2 * CNT_W + 5;
  localparam int unsigned MODE_W = 2 * CNT_W + 6;
  localparam logic [MODE_W-1:0] MODE_RST = {MODE_W{1'b1}} ^
    ((MODE_W'(1) << P_IRQ) | (MODE_W'(1) << P_PROC) | (MODE_W'(1) << P_DIS));

  logic [MODE_W-1:0] mode_q;
  logic              mode_wr;

  assign mode_wr     = bus_sel && bus_wr && (bus_addr == SEL_MODE);
  assign restart_req = bus_sel && bus_wr && (bus_addr == SEL_CTRL) &&
                       (bus_wdata[DW-1 -: KEY_W] == KEY) && bus_wdata[0];
  assign stat_rd     = bus_sel && !bus_wr && (bus_addr == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_RST;
    else if (mode_wr) mode_q <= bus_wdata[MODE_W-1:0];
  end

  assign cfg_reload = mode_q[CNT_W-1:0];
  assign cfg_irq_en = mode_q[P_IRQ];
  assign cfg_rst_en = mode_q[P_RST];
  assign cfg_proc   = mode_q[P_PROC];
  assign cfg_dis    = mode_q[P_DIS];
  assign cfg_delta  = mode_q[P_DLO +: CNT_W];
  assign cfg_hdbg   = mode_q[P_HDBG];
  assign cfg_hidl   = mode_q[P_HIDL];

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        SEL_MODE: bus_rdata = DW'(mode_q);
        SEL_STAT: bus_rdata = DW'({stat_err, stat_uf});
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2: the configuration word only changes on a write to word 1
  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q));
  // R2: a write to word 1 stores the low bits of the data
  assert_mode_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (mode_q == $past(bus_wdata[MODE_W-1:0])));
endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             restart_req,
  input  logic             dbg_active,
  input  logic             idle_active,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic [CNT_W-1:0] cfg_delta,
  input  logic             cfg_dis,
  input  logic             cfg_hdbg,
  input  logic             cfg_hidl,
  output logic             uf_evt,
  output logic             err_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             running;
  logic             restart_ok;

  assign running    = !cfg_dis && !(cfg_hdbg && dbg_active) && !(cfg_hidl && idle_active);
  assign restart_ok = restart_req && !cfg_dis;
  assign err_evt    = restart_ok && (cnt_q > cfg_delta);
  assign uf_evt     = running && tick_en && !restart_ok && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (restart_ok) begin
      if (!err_evt) cnt_q <= cfg_reload;
    end else if (running && tick_en) begin
      if (cnt_q <= CNT_W'(1)) cnt_q <= cfg_reload;
      else                    cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // R4: an underflow leaves the count at the reload value
  assert_uf_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uf_evt |=> (cnt_q == $past(cfg_reload)));
  // R5: an early service command leaves the count alone
  assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> $stable(cnt_q));
  // R8: a frozen counter without a service command holds
  assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !restart_ok) |=> $stable(cnt_q));
  // R9: a switched-off timer never moves
  assert_off_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dis |=> $stable(cnt_q));
  // R10: underflow and error never share a cycle
  assert_one_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(uf_evt && err_evt));
endmodule

// File: rtl/wwd_fault.sv
module wwd_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic uf_evt,
  input  logic err_evt,
  input  logic stat_rd,
  input  logic cfg_irq_en,
  input  logic cfg_rst_en,
  input  logic cfg_proc,
  output logic fault_irq,
  output logic cpu_rst,
  output logic sys_rst,
  output logic stat_uf,
  output logic stat_err
);
  logic fault;
  assign fault = uf_evt || err_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_irq <= 1'b0;
      cpu_rst   <= 1'b0;
      sys_rst   <= 1'b0;
      stat_uf   <= 1'b0;
      stat_err  <= 1'b0;
    end else begin
      fault_irq <= fault && cfg_irq_en;
      cpu_rst   <= fault && cfg_rst_en && cfg_proc;
      sys_rst   <= fault && cfg_rst_en && !cfg_proc;
      stat_uf   <= uf_evt  || (stat_uf  && !stat_rd);
      stat_err  <= err_evt || (stat_err && !stat_rd);
    end
  end

  // R6: the interrupt only follows a fault with the enable set
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_irq |-> $past(cfg_irq_en && fault));
  // R6: the two reset outputs never fire together
  assert_rst_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_rst && sys_rst));
  // R7: an underflow bit survives until a read
  assert_uf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_uf && !stat_rd) |=> stat_uf);
  // R7: an error always lands in the event word
  assert_err_logged_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> stat_err);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int unsigned CNT_W = 12,
  parameter logic [7:0]  KEY   = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          dbg_active,
  input  logic          idle_active,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          fault_irq,
  output logic          cpu_rst,
  output logic          sys_rst
);
  logic             restart_req, stat_rd, stat_uf, stat_err;
  logic             uf_evt, err_evt;
  logic [CNT_W-1:0] cfg_reload, cfg_delta;
  logic             cfg_irq_en, cfg_rst_en, cfg_proc, cfg_dis, cfg_hdbg, cfg_hidl;

  wwd_regs #(.CNT_W(CNT_W), .KEY(KEY)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_uf(stat_uf),
    .stat_err(stat_err), .bus_rdata(bus_rdata), .restart_req(restart_req),
    .stat_rd(stat_rd), .cfg_reload(cfg_reload), .cfg_delta(cfg_delta),
    .cfg_irq_en(cfg_irq_en), .cfg_rst_en(cfg_rst_en), .cfg_proc(cfg_proc),
    .cfg_dis(cfg_dis), .cfg_hdbg(cfg_hdbg), .cfg_hidl(cfg_hidl)
  );

  wwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart_req(restart_req),
    .dbg_active(dbg_active), .idle_active(idle_active),
    .cfg_reload(cfg_reload), .cfg_delta(cfg_delta), .cfg_dis(cfg_dis),
    .cfg_hdbg(cfg_hdbg), .cfg_hidl(cfg_hidl),
    .uf_evt(uf_evt), .err_evt(err_evt)
  );

  wwd_fault u_fault (
    .clk(clk), .rst_n(rst_n), .uf_evt(uf_evt), .err_evt(err_evt),
    .stat_rd(stat_rd), .cfg_irq_en(cfg_irq_en), .cfg_rst_en(cfg_rst_en),
    .cfg_proc(cfg_proc), .fault_irq(fault_irq), .cpu_rst(cpu_rst),
    .sys_rst(sys_rst), .stat_uf(stat_uf), .stat_err(stat_err)
  );
endmodule

// File: tb/tb_win_watchdog.sv
module tb_win_watchdog;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 0, rst_n = 0, tick_en = 0, dbg_active = 0, idle_active = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic fault_irq, cpu_rst, sys_rst;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_watchdog #(.CNT_W(W)) dut (.*);

  function automatic logic [31:0] mw(int rl, int dl, bit irq, bit rs, bit pr,
                                     bit off, bit hd, bit hi);
    return 32'(rl) | (32'(irq) << W) | (32'(rs) << (W+1)) | (32'(pr) << (W+2)) |
           (32'(off) << (W+3)) | (32'(dl) << (W+4)) | (32'(hd) << (2*W+4)) |
           (32'(hi) << (2*W+5));
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, input bit tk, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; tick_en = tk;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0; tick_en = 0;
  endtask

  task automatic kick(input bit tk);
    wr(2'd0, 32'hA500_0001, tk);
  endtask

  // n ticks, returns how many showed an interrupt pulse
  task automatic ticks(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1;
      @(negedge clk); tick_en = 0;
      if (fault_irq) hits++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int h;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "outputs", {29'b0, fault_irq, cpu_rst, sys_rst}, 0);
    rd(2'd1, 0, d); chk("R1", "mode reset", d, mw(MAXC, MAXC, 0, 1, 0, 0, 1, 1));
    rd(2'd2, 0, d); chk("R1", "status reset", d, 0);
    // R2 layout and readback
    wr(2'd1, 32'hFFFF_2A5B, 0);
    rd(2'd1, 0, d); chk("R2", "mode readback", d, 32'h2A5B);
    wr(2'd2, 32'h0000_1234, 0);
    rd(2'd1, 0, d); chk("R2", "mode kept after other write", d, 32'h2A5B);
    rd(2'd0, 0, d); chk("R2", "ctrl reads zero", d, 0);
    rd(2'd3, 0, d); chk("R2", "word3 reads zero", d, 0);
    // R4 underflow period sweep
    for (int r = 0; r <= MAXC; r++) begin
      int n;
      wr(2'd1, mw(r, MAXC, 1, 0, 0, 0, 0, 0), 0);
      kick(0);
      rd(2'd2, 0, d);
      n = (r < 1) ? 1 : r;
      ticks(n - 1, h); chk("R4", $sformatf("early pulses reload %0d", r), h, 0);
      ticks(1, h);     chk("R4", $sformatf("underflow tick reload %0d", r), h, 1);
      @(negedge clk);  chk("R6", "pulse one cycle", fault_irq, 0);
      rd(2'd2, 0, d);  chk("R7", "underflow flag", d, 1);
    end
    // R5 window sweep over count and limit
    for (int v = 1; v <= MAXC; v++) begin
      for (int dl = 0; dl <= MAXC; dl++) begin
        int rem;
        bit e;
        wr(2'd1, mw(MAXC, MAXC, 1, 0, 0, 0, 0, 0), 0);
        kick(0);
        ticks(MAXC - v, h);
        rd(2'd2, 0, d);
        wr(2'd1, mw(MAXC, dl, 1, 0, 0, 0, 0, 0), 0);
        kick(0);
        e = (v > dl);
        chk("R5", $sformatf("err pulse v%0d d%0d", v, dl), fault_irq, e);
        rd(2'd2, 0, d);
        chk("R5", $sformatf("err flag v%0d d%0d", v, dl), d, e ? 2 : 0);
        rem = e ? v : MAXC;
        ticks(rem - 1, h);
        chk("R5", $sformatf("count after v%0d d%0d", v, dl), h, 0);
        ticks(1, h);
        chk("R5", $sformatf("underflow after v%0d d%0d", v, dl), h, 1);
      end
    end
    // R3 key and bit0 filtering
    wr(2'd1, mw(MAXC, 3, 1, 0, 0, 0, 0, 0), 0);
    wr(2'd1, mw(MAXC, MAXC, 1, 0, 0, 0, 0, 0), 0);
    kick(0);
    wr(2'd1, mw(MAXC, 3, 1, 0, 0, 0, 0, 0), 0);
    ticks(MAXC - 5, h);
    rd(2'd2, 0, d);
    wr(2'd0, 32'h5A00_0001, 0); chk("R3", "bad key no pulse", fault_irq, 0);
    wr(2'd0, 32'hA500_0000, 0); chk("R3", "bit0 clear no pulse", fault_irq, 0);
    rd(2'd2, 0, d); chk("R3", "ignored writes no flag", d, 0);
    ticks(4, h); chk("R3", "count untouched", h, 0);
    ticks(1, h); chk("R3", "underflow at kept count", h, 1);
    wr(2'd1, mw(MAXC, MAXC, 1, 0, 0, 0, 0, 0), 0);
    kick(0); ticks(10, h); kick(0);
    ticks(MAXC - 1, h); chk("R3", "good restart reloads", h, 0);
    ticks(1, h); chk("R3", "underflow after reload", h, 1);
    // R6 routing, all enable combinations
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, mw(2, MAXC, c[0], c[1], c[2], 0, 0, 0), 0);
      kick(0);
      ticks(1, h);
      ticks(1, h);
      chk("R6", $sformatf("routing combo %0d", c), {fault_irq, cpu_rst, sys_rst},
          {c[0], c[1] & c[2], c[1] & ~c[2]});
    end
    wr(2'd1, mw(MAXC, MAXC, 0, 1, 0, 0, 0, 0), 0);
    kick(0);
    wr(2'd1, mw(MAXC, 0, 0, 1, 0, 0, 0, 0), 0);
    kick(0);
    chk("R6", "error drives system reset", {fault_irq, cpu_rst, sys_rst}, 3'b001);
    rd(2'd2, 0, d);
    // R7 sticky and read/event collision
    wr(2'd1, mw(1, MAXC, 1, 0, 0, 0, 0, 0), 0);
    kick(0);
    ticks(2, h); chk("R7", "two underflows", h, 2);
    rd(2'd2, 0, d); chk("R7", "sticky after two", d, 1);
    rd(2'd2, 0, d); chk("R7", "cleared by read", d, 0);
    rd(2'd2, 1, d); chk("R7", "read sees old value", d, 0);
    rd(2'd2, 0, d); chk("R7", "event during read kept", d, 1);
    // R8 debug and idle freeze
    wr(2'd1, mw(3, MAXC, 1, 0, 0, 0, 1, 0), 0);
    kick(0);
    dbg_active = 1; ticks(5, h); chk("R8", "debug freeze holds", h, 0);
    dbg_active = 0; ticks(2, h); chk("R8", "resume no early", h, 0);
    ticks(1, h); chk("R8", "resume underflow", h, 1);
    wr(2'd1, mw(3, MAXC, 1, 0, 0, 0, 0, 1), 0);
    kick(0);
    dbg_active = 1; ticks(3, h); chk("R8", "debug ignored when bit clear", h, 1);
    dbg_active = 0;
    kick(0);
    idle_active = 1; ticks(5, h); chk("R8", "idle freeze holds", h, 0);
    kick(0); idle_active = 0;
    ticks(3, h); chk("R8", "restart while frozen", h, 1);
    wr(2'd1, mw(3, MAXC, 1, 0, 0, 0, 1, 0), 0);
    kick(0);
    idle_active = 1; ticks(3, h); chk("R8", "idle ignored when bit clear", h, 1);
    idle_active = 0;
    // R9 off
    rd(2'd2, 0, d);
    wr(2'd1, mw(2, 0, 1, 1, 0, 1, 0, 0), 0);
    ticks(6, h); chk("R9", "no underflow when off", h, 0);
    kick(0); chk("R9", "no error when off", {fault_irq, cpu_rst, sys_rst}, 0);
    rd(2'd2, 0, d); chk("R9", "no flags when off", d, 0);
    // R10 restart beats a same-cycle tick
    wr(2'd1, mw(3, MAXC, 1, 0, 0, 0, 0, 0), 0);
    kick(0); ticks(2, h);
    kick(1); chk("R10", "tick dropped with restart", fault_irq, 0);
    ticks(2, h); chk("R10", "full period after", h, 0);
    ticks(1, h); chk("R10", "underflow after", h, 1);
    // R11 mode write keeps count
    wr(2'd1, mw(MAXC, MAXC, 1, 0, 0, 0, 0, 0), 0);
    kick(0); ticks(MAXC - 3, h);
    wr(2'd1, mw(1, MAXC, 1, 0, 0, 0, 0, 0), 0);
    ticks(2, h); chk("R11", "count survives mode write", h, 0);
    ticks(1, h); chk("R11", "underflow at old count", h, 1);
    ticks(1, h); chk("R11", "new reload after underflow", h, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule